// File: doc/BRIEF.md
# Leaf Entry Permission Check and Reference/Change Update

This block sits after a page table walker. It accepts one fetched 64-bit leaf translation entry at a time, together with the memory address the entry came from, the kind of access (instruction fetch, data load or data store), whether the requester runs in problem (user) state, whether the check belongs to the partition-scoped stage, and a 3-bit permission mask from the authority-mask register. From these it works out which of read, write and execute the page grants. It then decides whether the requested access may proceed.

When the access is allowed, the block sets the entry's reference bit, and also its change bit on a store. If that alters the entry, the block writes the new value back through a single-beat write port and waits for the acknowledge before it reports completion. When the access is denied, nothing is written and a fault cause word is returned instead. For loads and fetches, the returned permission mask never includes write. This forces a later store to come back through the block and set the change bit.

Encodings used throughout: access type 0 = fetch, 1 = load, 2 = store (3 is treated as a load). Entry bits [0], [1] and [2] are the page's read, write and execute grants. Bit 3 marks a privileged-only page. Bits [5:4] hold the page attribute, and the value 2'b11 means non-idempotent I/O. Bit 7 is the change bit and bit 8 is the reference bit. The permission input and output use the same read [0], write [1], execute [2] layout. Cause word bits: bit 27 = no-execute/guarded, bit 26 = protection fault, bit 25 = access was a store.

Top module: `pte_perm_rc`

## Requirements
- R1: A fetch to a page whose attribute field [5:4] equals 2'b11 is denied with cause exactly bit 27, whatever the permission bits say.
- R2: In a process-scoped check (partition flag 0), a page with bit 3 set that is accessed in problem state grants nothing, so every access type is denied.
- R3: In a process-scoped check in privileged state, a page with bit 3 clear grants entry bits [2:0] ANDed with the authority-mask input.
- R4: In every other case the grant equals entry bits [2:0] unchanged, and the authority-mask input has no effect (partition-scoped checks included).
- R5: An access whose required permission is missing (fetch needs bit 2, load needs bit 0, store needs bit 1) is denied. The cause is bit 27 for a fetch, bit 26 for a load, and bits 26 and 25 for a store. A denied result reports granted = 0 and a permission output of 0.
- R6: For an allowed access the new entry equals the fetched one with bit 8 set, and with bit 7 also set only for a store.
- R7: For an allowed load or fetch the permission output is the grant with write (bit 1) cleared. For an allowed store it is the full grant. The cause is 0.
- R8: A write-back to the entry's address with the new entry value is issued only when the access is allowed and the new value differs from the fetched one.
- R9: Without a write-back, done pulses in the cycle after the request. With one, the write request stays asserted with stable address and data until acknowledged, and done pulses in the cycle after the acknowledge.
- R10: A request presented while a write-back is pending is ignored. It produces no done and no write.
- R11: After reset, done and the write request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a check (accepted only when idle) |
| req_pte | input | 64 | Fetched leaf entry |
| req_addr | input | AW (48) | Memory address of the entry |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_prob | input | 1 | Requester is in problem state |
| req_part | input | 1 | Check belongs to the partition-scoped stage |
| amr_perm | input | 3 | Authority-mask permissions (R/W/X) |
| done | output | 1 | One-cycle completion pulse |
| granted | output | 1 | Access allowed (valid with done) |
| perm_out | output | 3 | Resulting permission mask |
| cause_out | output | CW (32) | Fault cause word |
| mem_wr_valid | output | 1 | Write-back request |
| mem_wr_addr | output | AW (48) | Write-back address |
| mem_wr_data | output | 64 | Updated entry |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
The main permission function is tried with all three access types against pages that are privileged or not, in problem and privileged state, under both scopes, with authority masks that either remove or keep the needed bit. Together these separate the zero-grant rule, the masked rule and the unmasked rule. Entries whose reference and change bits are already set, or not set, show whether a write-back happens only on a real change and whether store and non-store updates differ. Varying the acknowledge latency, and sending a second request during a pending write-back, exercise completion timing and the ignoring of requests while busy.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic {
    WB_IDLE  = 1'b0,
    WB_WRITE = 1'b1
  } wb_state_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // Permission a given access type requires (reserved type behaves as load)
  function automatic logic [2:0] need_perm(acc_e a);
    logic [2:0] n;
    n = '0;
    case (a)
      ACC_FETCH: n[PERM_X] = 1'b1;
      ACC_STORE: n[PERM_W] = 1'b1;
      default:   n[PERM_R] = 1'b1;
    endcase
    return n;
  endfunction

  // Grant selection: zero, masked, or plain encoded permissions
  function automatic logic [2:0] grant_perm(logic [2:0] eaa, logic [2:0] amr,
                                            logic priv_pg, logic prob,
                                            logic part);
    if (!part && priv_pg && prob) return 3'b000;
    if (part || prob || priv_pg)  return eaa;
    return eaa & amr;
  endfunction

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_perm_pkg::*;
#(
  parameter int PRIV_BIT   = 3,
  parameter int ATT_LSB    = 4,
  parameter logic [1:0] NIO_CODE = 2'b11,
  parameter int CW         = 32,
  parameter int C_NOEXEC   = 27,
  parameter int C_PROT     = 26,
  parameter int C_STORE    = 25
) (
  input  logic [63:0]   pte,
  input  acc_e          acc,
  input  logic          prob,
  input  logic          part,
  input  logic [2:0]    amr,
  output logic          allow,
  output logic          nio_fetch,
  output logic [2:0]    perm,
  output logic [CW-1:0] cause
);

  logic [2:0] grant;
  logic       miss;
  logic       deny;

  always_comb begin
    nio_fetch = (pte[ATT_LSB +: 2] == NIO_CODE) && (acc == ACC_FETCH);
    grant     = grant_perm(pte[2:0], amr, pte[PRIV_BIT], prob, part);
    miss      = |(need_perm(acc) & ~grant);
    deny      = nio_fetch | miss;
    allow     = ~deny;

    cause = '0;
    if (deny) begin
      if (acc == ACC_FETCH) begin
        cause[C_NOEXEC] = 1'b1;
      end else begin
        cause[C_PROT] = 1'b1;
        if (acc == ACC_STORE) cause[C_STORE] = 1'b1;
      end
    end

    if (deny)                  perm = 3'b000;
    else if (acc == ACC_STORE) perm = grant;
    else                       perm = grant & ~(3'b001 << PERM_W);
  end

endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
  import pte_perm_pkg::*;
#(
  parameter int REF_BIT = 8,
  parameter int CHG_BIT = 7
) (
  input  logic [63:0] pte,
  input  acc_e        acc,
  input  logic        allow,
  output logic [63:0] new_pte,
  output logic        need_wr
);

  always_comb begin
    new_pte          = pte;
    new_pte[REF_BIT] = 1'b1;
    if (acc == ACC_STORE) new_pte[CHG_BIT] = 1'b1;
    need_wr = allow && (new_pte != pte);
  end

endmodule

// File: rtl/pte_wb_fsm.sv
module pte_wb_fsm
  import pte_perm_pkg::*;
#(
  parameter int AW = 48,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          dec_allow,
  input  logic [2:0]    dec_perm,
  input  logic [CW-1:0] dec_cause,
  input  logic          need_wr,
  input  logic [63:0]   new_pte,
  input  logic [AW-1:0] addr,
  input  logic          wr_ack,
  output logic          accept,
  output logic          done,
  output logic          allow_q,
  output logic [2:0]    perm_q,
  output logic [CW-1:0] cause_q,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data
);

  wb_state_e state;

  assign accept   = req_valid && (state == WB_IDLE);
  assign wr_valid = (state == WB_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WB_IDLE;
      done    <= 1'b0;
      allow_q <= 1'b0;
      perm_q  <= '0;
      cause_q <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        WB_IDLE: begin
          if (accept) begin
            allow_q <= dec_allow;
            perm_q  <= dec_perm;
            cause_q <= dec_cause;
            wr_addr <= addr;
            wr_data <= new_pte;
            if (need_wr) state <= WB_WRITE;
            else         done  <= 1'b1;
          end
        end
        WB_WRITE: begin
          if (wr_ack) begin
            state <= WB_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= WB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pte_perm_rc.sv
module pte_perm_rc
  import pte_perm_pkg::*;
#(
  parameter int AW       = 48,
  parameter int CW       = 32,
  parameter int PRIV_BIT = 3,
  parameter int ATT_LSB  = 4,
  parameter logic [1:0] NIO_CODE = 2'b11,
  parameter int CHG_BIT  = 7,
  parameter int REF_BIT  = 8,
  parameter int C_NOEXEC = 27,
  parameter int C_PROT   = 26,
  parameter int C_STORE  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [63:0]   req_pte,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_acc,
  input  logic          req_prob,
  input  logic          req_part,
  input  logic [2:0]    amr_perm,
  output logic          done,
  output logic          granted,
  output logic [2:0]    perm_out,
  output logic [CW-1:0] cause_out,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [63:0]   mem_wr_data,
  input  logic          mem_wr_ack
);

  acc_e          acc;
  logic          dec_allow;
  logic          dec_nio;
  logic [2:0]    dec_perm;
  logic [CW-1:0] dec_cause;
  logic [63:0]   upd_pte;
  logic          upd_need;
  logic          accept;

  assign acc = acc_e'(req_acc);

  pte_perm_eval #(
    .PRIV_BIT(PRIV_BIT), .ATT_LSB(ATT_LSB), .NIO_CODE(NIO_CODE), .CW(CW),
    .C_NOEXEC(C_NOEXEC), .C_PROT(C_PROT), .C_STORE(C_STORE)
  ) u_eval (
    .pte(req_pte), .acc(acc), .prob(req_prob), .part(req_part),
    .amr(amr_perm), .allow(dec_allow), .nio_fetch(dec_nio),
    .perm(dec_perm), .cause(dec_cause)
  );

  pte_rc_update #(.REF_BIT(REF_BIT), .CHG_BIT(CHG_BIT)) u_rc (
    .pte(req_pte), .acc(acc), .allow(dec_allow),
    .new_pte(upd_pte), .need_wr(upd_need)
  );

  pte_wb_fsm #(.AW(AW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .dec_allow(dec_allow), .dec_perm(dec_perm), .dec_cause(dec_cause),
    .need_wr(upd_need), .new_pte(upd_pte), .addr(req_addr),
    .wr_ack(mem_wr_ack), .accept(accept), .done(done),
    .allow_q(granted), .perm_q(perm_out), .cause_q(cause_out),
    .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
  );

endmodule

// File: rtl/pte_perm_rc_chk.sv
module pte_perm_rc_chk #(
  parameter int AW      = 48,
  parameter int CW      = 32,
  parameter int REF_BIT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          dec_allow,
  input logic          upd_need,
  input logic [1:0]    req_acc,
  input logic          done,
  input logic          granted,
  input logic [2:0]    perm_out,
  input logic [CW-1:0] cause_out,
  input logic          mem_wr_valid,
  input logic [AW-1:0] mem_wr_addr,
  input logic [63:0]   mem_wr_data,
  input logic          mem_wr_ack
);

  logic was_store;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      was_store <= 1'b0;
    else if (accept) was_store <= (req_acc == 2'd2);
  end

  // R9: pending write holds its payload until acknowledged
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_addr));

  // R9: acknowledge ends the write and completes the request
  p_ack_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ack |=> done && !mem_wr_valid);

  // R9: an accepted request needing no write completes next cycle
  p_nowr_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(dec_allow && upd_need) |=> done && !mem_wr_valid);

  // R6: every written entry carries the reference bit
  p_wr_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_data[REF_BIT]);

  // R8: only allowed accesses write back
  p_wr_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> granted);

  // R7: non-store results never expose write permission
  p_nonstore_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && granted && !was_store |-> !perm_out[1]);

  // R5: denials report no permission and a nonzero cause
  p_deny_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !granted |-> perm_out == 3'b000 && cause_out != '0);

  // R10: no request accepted while a write is pending
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !accept);

endmodule

bind pte_perm_rc pte_perm_rc_chk #(.AW(AW), .CW(CW), .REF_BIT(REF_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .dec_allow(dec_allow),
  .upd_need(upd_need), .req_acc(req_acc), .done(done), .granted(granted),
  .perm_out(perm_out), .cause_out(cause_out), .mem_wr_valid(mem_wr_valid),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
);

// File: tb/sim_pte_perm_rc.sv
module sim_pte_perm_rc;

  localparam int AW = 48;
  localparam int CW = 32;

  typedef struct {
    logic          ok;
    logic [2:0]    perm;
    logic [CW-1:0] cause;
    logic          wr;
    logic [63:0]   wdata;
    logic [AW-1:0] waddr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [63:0]   req_pte = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_acc = '0;
  logic          req_prob = 1'b0;
  logic          req_part = 1'b0;
  logic [2:0]    amr_perm = '0;
  logic          done;
  logic          granted;
  logic [2:0]    perm_out;
  logic [CW-1:0] cause_out;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [63:0]   mem_wr_data;
  logic          mem_wr_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int ack_lat = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  pte_perm_rc u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
    .req_addr(req_addr), .req_acc(req_acc), .req_prob(req_prob),
    .req_part(req_part), .amr_perm(amr_perm), .done(done), .granted(granted),
    .perm_out(perm_out), .cause_out(cause_out), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  task automatic chk(input logic cond, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic exp_t model(logic [63:0] pte, logic [1:0] acc, logic prob,
                                 logic part, logic [2:0] amr, logic [AW-1:0] addr,
                                 string tag);
    exp_t e;
    logic [2:0] g;
    logic [2:0] need;
    logic [63:0] np;
    logic bad;
    if (part)                 g = pte[2:0];
    else if (prob && pte[3])  g = 3'b000;
    else if (prob || pte[3])  g = pte[2:0];
    else                      g = pte[2:0] & amr;
    need = (acc == 2'd0) ? 3'b100 : (acc == 2'd2) ? 3'b010 : 3'b001;
    bad  = ((g & need) == 3'b000) || (acc == 2'd0 && pte[5:4] == 2'b11);
    e.ok = !bad;
    e.cause = '0;
    if (bad) e.cause = (acc == 2'd0) ? 32'h0800_0000 :
                       (acc == 2'd2) ? 32'h0600_0000 : 32'h0400_0000;
    e.perm = bad ? 3'b000 : (acc == 2'd2) ? g : {g[2], 1'b0, g[0]};
    np = pte | 64'h100 | ((acc == 2'd2) ? 64'h80 : 64'h0);
    e.wr = !bad && (np != pte);
    e.wdata = np;
    e.waddr = addr;
    e.tag = tag;
    return e;
  endfunction

  task automatic run(input logic [63:0] pte, input logic [1:0] acc, input logic prob,
                     input logic part, input logic [2:0] amr, input int lat,
                     input string tag);
    exp_t e;
    logic [AW-1:0] a;
    a = {pte[31:0], 16'h0} ^ 48'h0000_1000_0008;
    e = model(pte, acc, prob, part, amr, a, tag);
    ack_lat = lat;
    q.push_back(e);
    @(negedge clk);
    req_pte = pte; req_acc = acc; req_prob = prob; req_part = part;
    amr_perm = amr; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!e.wr) chk(done === 1'b1, {tag, " R9 done next cycle"}, 64'(done), 64'd1);
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: serves write acknowledges and scores completions
  initial begin
    bit wr_seen = 0;
    bit ack_sent = 0;
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      mem_wr_ack = 1'b0;
      if (ack_sent) begin
        chk(done === 1'b1, "R9 done after ack", 64'(done), 64'd1);
        ack_sent = 0;
      end
      if (mem_wr_valid) begin
        if (!wr_seen) begin
          wr_seen = 1;
          wait_cnt = 0;
          if (q.size() != 0) begin
            chk(mem_wr_data === q[0].wdata, {q[0].tag, " R6 written entry"},
                mem_wr_data, q[0].wdata);
            chk(mem_wr_addr === q[0].waddr, {q[0].tag, " R8 write address"},
                64'(mem_wr_addr), 64'(q[0].waddr));
          end
        end
        if (wait_cnt >= ack_lat) begin
          mem_wr_ack = 1'b1;
          ack_sent = 1;
        end else begin
          wait_cnt++;
        end
      end
      if (done === 1'b1) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(granted === e.ok, {e.tag, " granted"}, 64'(granted), 64'(e.ok));
          chk(perm_out === e.perm, {e.tag, " perm"}, 64'(perm_out), 64'(e.perm));
          chk(cause_out === e.cause, {e.tag, " cause"}, 64'(cause_out), 64'(e.cause));
          chk(wr_seen == e.wr, {e.tag, " R8 write issued"}, 64'(wr_seen), 64'(e.wr));
        end
        wr_seen = 0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R11 reset done", 64'(done), 64'd0);
    chk(mem_wr_valid === 1'b0, "R11 reset write", 64'(mem_wr_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fetch to non-idempotent I/O page, executable bits set
    run(64'h0000_0000_0000_0037, 2'd0, 1'b0, 1'b1, 3'b111, 0, "R1 nio fetch");
    // R1 contrast: a load to the same page class is fine
    run(64'h0000_0000_0000_0037, 2'd1, 1'b0, 1'b1, 3'b111, 0, "R1 nio load ok");
    // R2: privileged page, problem state, process scope
    run(64'h0000_0000_0000_000F, 2'd1, 1'b1, 1'b0, 3'b111, 0, "R2 priv load");
    run(64'h0000_0000_0000_000F, 2'd2, 1'b1, 1'b0, 3'b111, 0, "R2 priv store");
    run(64'h0000_0000_0000_000F, 2'd0, 1'b1, 1'b0, 3'b111, 0, "R2 priv fetch");
    // R4: same page under partition scope is allowed
    run(64'h0000_0000_0000_000F, 2'd1, 1'b1, 1'b1, 3'b000, 2, "R4 part priv");
    // R3: privileged state, non-privileged page, mask removes write
    run(64'h0000_0000_0000_0007, 2'd2, 1'b0, 1'b0, 3'b101, 0, "R3 amr deny");
    run(64'h0000_0000_0000_0007, 2'd1, 1'b0, 1'b0, 3'b101, 1, "R3 amr load");
    run(64'h0000_0000_0000_0007, 2'd0, 1'b0, 1'b0, 3'b011, 0, "R3 amr fetch");
    // R4: problem state, non-privileged page ignores a zero mask
    run(64'h0000_0000_0000_0003, 2'd2, 1'b1, 1'b0, 3'b000, 3, "R4 prob store");
    // R4: privileged page, privileged state ignores mask
    run(64'h0000_0000_0000_000C, 2'd0, 1'b0, 1'b0, 3'b000, 0, "R4 priv exec");
    // R5/R7: load needs read
    run(64'h0000_0000_0000_0006, 2'd1, 1'b1, 1'b1, 3'b111, 0, "R5 no read");
    // R6/R8: reference already set, load needs no write
    run(64'h0000_0000_0000_0101, 2'd1, 1'b1, 1'b0, 3'b111, 0, "R8 ref set load");
    // R6/R8: reference set, change clear, store writes change
    run(64'h0000_0000_0000_0103, 2'd2, 1'b1, 1'b0, 3'b111, 1, "R6 store chg");
    // R8: both bits set, store writes nothing
    run(64'h0000_0000_0000_0183, 2'd2, 1'b1, 1'b0, 3'b111, 0, "R8 rc set store");
    // R7: fetch on rwx page, write withheld
    run(64'hABCD_0000_0000_0187, 2'd0, 1'b1, 1'b1, 3'b111, 0, "R7 fetch rwx");

    // R10: second request during pending write is ignored
    begin
      exp_t e;
      logic [AW-1:0] a;
      a = 48'h0000_7777_0000;
      e = model(64'h0000_0000_0000_0003, 2'd2, 1'b1, 1'b0, 3'b111, a, "R10 first");
      ack_lat = 4;
      q.push_back(e);
      @(negedge clk);
      req_pte = 64'h3; req_acc = 2'd2; req_prob = 1'b1; req_part = 1'b0;
      amr_perm = 3'b111; req_addr = a; req_valid = 1'b1;
      @(negedge clk);
      req_pte = 64'h4; req_acc = 2'd1; req_addr = 48'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(done === 1'b0, "R10 no second done", 64'(done), 64'd0);
        chk(mem_wr_valid === 1'b0, "R10 no second write", 64'(mem_wr_valid), 64'd0);
      end
    end

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule